// File: doc/BRIEF.md
# ADC Result Ring Buffer

This block stores converted samples from a 10-bit analog-to-digital converter in a small ring of four slots. Software then drains them one byte-wide read at a time. Each valid result goes into the slot at the write pointer, and that pointer then steps on with wrap-around. A read pointer selects the slot shown on the two read-data bytes. The read pointer steps forward when software reads the byte that completes a sample. Which byte that is depends on how the result is justified.

The block reports three things: whether unread data is waiting, whether an unread slot was overwritten, and a periodic interrupt pulse. The pulse fires every one, two or four buffered writes. A conversion-sequence start empties the ring and re-aligns every pointer to slot 0. With buffering switched off, results go to a single holding register instead and the ring stays untouched.

Top module: `adc_ring_buf`

## Requirements
- R1: With `buf_en`=1, each `res_valid` result is stored in the slot at the write pointer, and the write pointer then steps 0→1→2→3→0. Without overwrites, reads return the results in the order they were written.
- R2: Byte formatting of the word `w` presented for reading. When `right_just`=1, `hi_byte` = {6'b0, w[9:8]} and `lo_byte` = w[7:0]. When `right_just`=0, `hi_byte` = w[9:2] and `lo_byte` = {w[1:0], 6'b0}.
- R3: `empty` is 1 whenever no unread entry is held. It drops in the cycle after a buffered write and returns to 1 once the last unread entry has been read.
- R4: An advancing read is a one-cycle `rd_lo` pulse when `right_just`=1, or a `rd_hi` pulse when `right_just`=0, with `buf_en`=1. It steps `rd_ptr` by one with wrap, visible the next cycle. A pulse on the other byte strobe leaves `rd_ptr` unchanged, and so does an advancing read while `empty`=1.
- R5: A buffered write that finds four unread entries sets `overflow` unless an advancing read happens in the same cycle. The slot at the write pointer is overwritten and the entry count stays at four. `overflow` stays set until an `ovf_clr` pulse, and a same-cycle set wins over the clear.
- R6: `trig_lvl` selects the interrupt rate: 0 on every buffered write, 1 on every second, 2 on every fourth, and 3 (reserved) on every write. Writes are counted from the last sequence start. `irq` is a one-cycle pulse in the cycle after the qualifying write.
- R7: A `seq_start` pulse resets the read pointer, the write pointer and the interrupt write counter to 0 and marks the ring empty. A result in the same cycle is discarded while buffering is on. `overflow` is kept.
- R8: With `buf_en`=0, each result loads a single holding register, and both read bytes show it formatted as in R2. `irq` pulses after every such result. `empty`, `rd_ptr` and `overflow` are unchanged, and byte strobes have no effect.
- R9: A buffered write and an advancing read in the same cycle are both performed. The read bytes show the slot's contents before the write, the entry count is unchanged and `overflow` is not set.
- R10: After reset, `rd_ptr`=0, `empty`=1, `overflow`=0, `irq`=0, and both read bytes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_en | input | 1 | 1 = ring buffering, 0 = single holding register |
| right_just | input | 1 | 1 = right-justified bytes, 0 = left-justified |
| trig_lvl | input | 2 | Interrupt rate select |
| seq_start | input | 1 | Conversion sequence start pulse |
| res_valid | input | 1 | Converter result valid strobe |
| res_data | input | 10 | Converter result |
| rd_lo | input | 1 | Low result byte read strobe |
| rd_hi | input | 1 | High result byte read strobe |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| lo_byte | output | 8 | Low result byte of the selected entry |
| hi_byte | output | 8 | High result byte of the selected entry |
| rd_ptr | output | 2 | Slot selected for the next read |
| empty | output | 1 | No unread entry held |
| overflow | output | 1 | An unread entry was overwritten |
| irq | output | 1 | Interrupt pulse |

## Verification
The ring is filled and drained in both justifications with bit patterns that make swapped or misaligned bytes visible. Writing five results without reading shows whether the overwrite lands in the oldest slot and whether the flag sticks. Writing while a read happens on a full ring separates old-data return from an overflow. Interrupt counting runs after a fresh sequence start at each of the four rate settings. Bypass writes, wrong-byte strobes and reads of an empty ring check that none of them disturbs the pointers or flags.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    typedef enum logic [1:0] {
        TRIG_EACH   = 2'd0,
        TRIG_SECOND = 2'd1,
        TRIG_FOURTH = 2'd2,
        TRIG_RSVD   = 2'd3
    } trig_e;

endpackage

// File: rtl/adc_rb_ctrl.sv
module adc_rb_ctrl #(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          seq_start,
    input  logic          wr_req,
    input  logic          pop_req,
    input  logic          ovf_clr,
    output logic          wr_fire,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          empty,
    output logic          overflow
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  do_wr, do_pop;

    always_comb begin
        st_d   = st_q;
        do_wr  = en && wr_req && !seq_start;
        do_pop = en && pop_req && !seq_start && (st_q.cnt != '0);

        if (seq_start) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_wr) begin
                st_d.wr = st_q.wr + AW'(1);
            end
            if (do_pop) begin
                st_d.rd = st_q.rd + AW'(1);
            end
            unique case ({do_wr, do_pop})
                2'b10: begin
                    if (st_q.cnt != FULL_CNT) begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end

        if (do_wr && !do_pop && (st_q.cnt == FULL_CNT)) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_fire  = do_wr;
    assign wr_ptr   = st_q.wr;
    assign rd_ptr   = st_q.rd;
    assign empty    = (st_q.cnt == '0);
    assign overflow = st_q.ovf;

endmodule

// File: rtl/adc_rb_store.sv
module adc_rb_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 10,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] din,
    input  logic [AW-1:0]     rd_ptr,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en && (wr_ptr == AW'(i))) begin
                slot_d[i] = din;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign dout = slot_q[rd_ptr];

endmodule

// File: rtl/adc_rb_irq.sv
module adc_rb_irq
    import adc_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_start,
    input  logic       buf_wr,
    input  logic       byp_wr,
    input  logic [1:0] level,
    output logic       irq
);

    typedef struct packed {
        logic [1:0] wcnt;
        logic       pulse;
    } irq_t;

    irq_t  st_d, st_q;
    trig_e lvl;

    always_comb begin
        lvl        = trig_e'(level);
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (byp_wr) begin
            st_d.pulse = 1'b1;
        end

        if (seq_start) begin
            st_d.wcnt = '0;
        end else if (buf_wr) begin
            st_d.wcnt = st_q.wcnt + 2'd1;
            unique case (lvl)
                TRIG_SECOND: st_d.pulse = st_q.wcnt[0];
                TRIG_FOURTH: st_d.pulse = (st_q.wcnt == 2'd3);
                default:     st_d.pulse = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pulse;

endmodule

// File: rtl/adc_rb_fmt.sv
module adc_rb_fmt #(
    parameter int DATA_W = 10,
    parameter int BYTE_W = 8,
    localparam int PAD_W = 2 * BYTE_W - DATA_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic              right_just,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);

    logic [2*BYTE_W-1:0] packed_w;

    always_comb begin
        if (right_just) begin
            packed_w = {{PAD_W{1'b0}}, word};
        end else begin
            packed_w = {word, {PAD_W{1'b0}}};
        end
        hi = packed_w[2*BYTE_W-1:BYTE_W];
        lo = packed_w[BYTE_W-1:0];
    end

endmodule

// File: rtl/adc_ring_buf.sv
module adc_ring_buf #(
    parameter int DATA_W = 10,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_en,
    input  logic              right_just,
    input  logic [1:0]        trig_lvl,
    input  logic              seq_start,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [AW-1:0]     rd_ptr,
    output logic              empty,
    output logic              overflow,
    output logic              irq
);

    logic              pop_req;
    logic              wr_fire;
    logic              byp_wr;
    logic [AW-1:0]     wr_ptr;
    logic [DATA_W-1:0] slot_word;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] byp_d, byp_q;

    assign pop_req = right_just ? rd_lo : rd_hi;
    assign byp_wr  = !buf_en && res_valid;

    adc_rb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (buf_en),
        .seq_start (seq_start),
        .wr_req    (res_valid),
        .pop_req   (pop_req),
        .ovf_clr   (ovf_clr),
        .wr_fire   (wr_fire),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .empty     (empty),
        .overflow  (overflow)
    );

    adc_rb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_fire),
        .wr_ptr (wr_ptr),
        .din    (res_data),
        .rd_ptr (rd_ptr),
        .dout   (slot_word)
    );

    adc_rb_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_start (seq_start),
        .buf_wr    (wr_fire),
        .byp_wr    (byp_wr),
        .level     (trig_lvl),
        .irq       (irq)
    );

    always_comb begin
        byp_d = byp_q;
        if (byp_wr) begin
            byp_d = res_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= '0;
        end else begin
            byp_q <= byp_d;
        end
    end

    assign sel_word = buf_en ? slot_word : byp_q;

    adc_rb_fmt #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fmt (
        .word       (sel_word),
        .right_just (right_just),
        .hi         (hi_byte),
        .lo         (lo_byte)
    );

endmodule

// File: rtl/adc_ring_buf_chk.sv
module adc_ring_buf_chk #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_en,
    input logic             right_just,
    input logic             seq_start,
    input logic             res_valid,
    input logic             rd_lo,
    input logic             rd_hi,
    input logic             ovf_clr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             empty,
    input logic             overflow,
    input logic             irq
);

    logic adv_rd;
    assign adv_rd = buf_en && (right_just ? rd_lo : rd_hi);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (empty && rd_ptr == '0));

    p_irq_after_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(res_valid));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(res_valid && buf_en && !seq_start));

    p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !seq_start) |=> $stable(rd_ptr));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_rd && !empty && !seq_start) |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));

    p_no_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_rd && !seq_start) |=> $stable(rd_ptr));

    p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && res_valid && !seq_start) |=> !empty);

    p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && !seq_start) |=> ($stable(empty) && $stable(rd_ptr)));

endmodule

bind adc_ring_buf adc_ring_buf_chk #(.PTR_W($clog2(DEPTH))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_en     (buf_en),
    .right_just (right_just),
    .seq_start  (seq_start),
    .res_valid  (res_valid),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .ovf_clr    (ovf_clr),
    .rd_ptr     (rd_ptr),
    .empty      (empty),
    .overflow   (overflow),
    .irq        (irq)
);

// File: tb/adc_ring_buf_test.sv
`timescale 1ns/1ps
module adc_ring_buf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_en = 1'b0;
    logic       right_just = 1'b1;
    logic [1:0] trig_lvl = 2'd0;
    logic       seq_start = 1'b0;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] lo_byte, hi_byte;
    logic [1:0] rd_ptr;
    logic       empty, overflow, irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_ring_buf uut (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .right_just(right_just),
        .trig_lvl(trig_lvl), .seq_start(seq_start), .res_valid(res_valid),
        .res_data(res_data), .rd_lo(rd_lo), .rd_hi(rd_hi), .ovf_clr(ovf_clr),
        .lo_byte(lo_byte), .hi_byte(hi_byte), .rd_ptr(rd_ptr), .empty(empty),
        .overflow(overflow), .irq(irq)
    );

    // requirement-level model
    logic [9:0] m_mem [4];
    logic [9:0] m_byp = '0;
    int m_wp = 0, m_rp = 0, m_cnt = 0, m_wc = 0;
    bit m_ovf = 0, m_irq = 0;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        string      tag;
    } rd_exp_t;
    rd_exp_t sb_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void fmt(input logic [9:0] w, input logic rj,
                                output logic [7:0] h, output logic [7:0] l);
        if (rj) begin
            h = {6'b0, w[9:8]};
            l = w[7:0];
        end else begin
            h = w[9:2];
            l = {w[1:0], 6'b0};
        end
    endfunction

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_lo || rd_hi) begin
                if (sb_q.size() == 0) begin
                    chk(0, "scoreboard underflow", 0, 1);
                end else begin
                    rd_exp_t e;
                    e = sb_q.pop_front();
                    chk(hi_byte == e.hi, {e.tag, " hi_byte"}, hi_byte, e.hi);
                    chk(lo_byte == e.lo, {e.tag, " lo_byte"}, lo_byte, e.lo);
                end
            end
        end
    end

    // driver: one cycle of stimulus, model update, flag checks
    task automatic step(input bit wr, input logic [9:0] v, input bit lo, input bit hi,
                        input bit clr, input bit st, input string tag);
        bit adv;
        bit set_ovf;
        if (lo || hi) begin
            rd_exp_t e;
            fmt(buf_en ? m_mem[m_rp] : m_byp, right_just, e.hi, e.lo);
            e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        res_valid = wr; res_data = v; rd_lo = lo; rd_hi = hi; ovf_clr = clr; seq_start = st;
        @(negedge clk);
        res_valid = 0; rd_lo = 0; rd_hi = 0; ovf_clr = 0; seq_start = 0;

        m_irq = 0;
        set_ovf = 0;
        adv = buf_en && !st && (right_just ? lo : hi) && (m_cnt != 0);
        if (wr && !buf_en) begin
            m_byp = v;
            m_irq = 1;
        end
        if (st) begin
            m_wp = 0; m_rp = 0; m_cnt = 0; m_wc = 0;
        end else begin
            if (wr && buf_en) begin
                if (m_cnt == 4 && !adv) set_ovf = 1;
                m_mem[m_wp] = v;
                m_wp = (m_wp + 1) % 4;
                case (trig_lvl)
                    2'd1:    m_irq = (m_wc % 2 == 1);
                    2'd2:    m_irq = (m_wc == 3);
                    default: m_irq = 1;
                endcase
                m_wc = (m_wc + 1) % 4;
                if (!adv && m_cnt < 4) m_cnt++;
            end
            if (adv) begin
                m_rp = (m_rp + 1) % 4;
                if (!(wr && buf_en)) m_cnt--;
            end
        end
        if (set_ovf) m_ovf = 1;
        else if (clr) m_ovf = 0;

        chk(irq == m_irq, {tag, " irq"}, irq, m_irq);
        chk(rd_ptr == 2'(m_rp), {tag, " rd_ptr"}, rd_ptr, m_rp);
        chk(empty == (m_cnt == 0), {tag, " empty"}, empty, m_cnt == 0);
        chk(overflow == m_ovf, {tag, " overflow"}, overflow, m_ovf);
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(rd_ptr == 0, "R10 rd_ptr", rd_ptr, 0);
        chk(empty == 1, "R10 empty", empty, 1);
        chk(overflow == 0, "R10 overflow", overflow, 0);
        chk(irq == 0, "R10 irq", irq, 0);
        chk(lo_byte == 0 && hi_byte == 0, "R10 bytes", {hi_byte, lo_byte}, 0);

        // R1/R3 fill, R2 right-justified drain
        buf_en = 1; right_just = 1; trig_lvl = 2'd0;
        step(1, 10'h3A5, 0, 0, 0, 0, "R1 fill");
        step(1, 10'h0F0, 0, 0, 0, 0, "R3 fill");
        step(1, 10'h1C3, 0, 0, 0, 0, "R1 fill");
        step(1, 10'h27E, 0, 0, 0, 0, "R1 fill");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, "R2 right drain");
        // R4 advancing read on empty ring
        step(0, '0, 1, 0, 0, 0, "R4 empty read");
        // R4 wrong byte strobe, then left justified read
        step(1, 10'h155, 0, 0, 0, 0, "R4 load");
        step(0, '0, 0, 1, 0, 0, "R4 wrong byte");
        right_just = 0;
        step(0, '0, 1, 0, 0, 0, "R4 wrong byte left");
        step(0, '0, 0, 1, 0, 0, "R2 left read");

        // R5 overflow
        right_just = 1;
        step(0, '0, 0, 0, 0, 1, "R7 start");
        step(1, 10'h001, 0, 0, 0, 0, "R5 fill");
        step(1, 10'h002, 0, 0, 0, 0, "R5 fill");
        step(1, 10'h004, 0, 0, 0, 0, "R5 fill");
        step(1, 10'h008, 0, 0, 0, 0, "R5 fill");
        step(1, 10'h3F0, 0, 0, 0, 0, "R5 overwrite");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, "R5 drain after overwrite");
        step(0, '0, 0, 0, 1, 0, "R5 clear");
        for (int i = 0; i < 4; i++) step(1, 10'(i * 99 + 7), 0, 0, 0, 0, "R5 refill");
        step(1, 10'h2AA, 0, 0, 1, 0, "R5 set beats clear");
        step(0, '0, 0, 0, 1, 0, "R5 clear");

        // R9 write and read together on a full ring
        step(0, '0, 0, 0, 0, 1, "R7 start");
        for (int i = 0; i < 4; i++) step(1, 10'(i * 131 + 40), 0, 0, 0, 0, "R9 fill");
        step(1, 10'h333, 1, 0, 0, 0, "R9 write with read");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, "R9 drain");

        // R6 interrupt rates
        for (int l = 1; l < 4; l++) begin
            trig_lvl = 2'(l);
            step(0, '0, 0, 0, 0, 1, "R7 start");
            for (int i = 0; i < 4; i++) step(1, 10'(l * 50 + i), 0, 0, 0, 0, "R6 rate");
        end
        trig_lvl = 2'd0;

        // R7 start keeps overflow, discards a same-cycle result
        step(1, 10'h111, 0, 0, 0, 0, "R7 overflow set");
        chk(overflow == 1, "R7 overflow before start", overflow, 1);
        step(1, 10'h222, 0, 0, 0, 1, "R7 start with result");
        chk(empty == 1 && overflow == 1, "R7 start result", {empty, overflow}, 3);
        step(0, '0, 0, 0, 1, 0, "R5 clear");

        // R8 bypass
        step(1, 10'h0A5, 0, 0, 0, 0, "R8 prefill");
        buf_en = 0;
        step(1, 10'h2C7, 0, 0, 0, 0, "R8 bypass write");
        step(0, '0, 1, 0, 0, 0, "R8 bypass read");
        right_just = 0;
        step(0, '0, 0, 1, 0, 0, "R8 bypass left read");
        buf_en = 1; right_just = 1;
        step(0, '0, 1, 0, 0, 0, "R8 ring intact");

        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard leftover", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule